// File: doc/BRIEF.md
# Plug-in Card Identification and Interrupt Register Set

This block is the slave-side register file of a plug-in I/O card sitting on a byte-wide peripheral bus. It claims a 64 KB window selected by the upper address bits. Inside that window only the low offset bits are decoded, so the three registers repeat at every 8-byte stride. Host software reads a hardwired identification byte to discover the card type. When the primary identifier is zero, it reads a second extension byte instead.

A status/control register carries the following fields:
- an interrupt enable;
- a sticky interrupt request that is fed by the card's functional core;
- the 2-bit interrupt level, taken either from switches or from writable control bits;
- two DMA enable bits.

When the request and the enable are both set, exactly one of four bus interrupt lines (levels 3 to 6) is raised. A write of any value to the identification address performs a soft reset of the card. That reset clears all writable state and produces a one-cycle reset pulse for the core.

Top module: `cardRegs`

## Requirements
- R1: An access whose address bits above bit 15 differ from the CARD_SLOT parameter changes no state and reads 0x00. Inside the window only address bits 2:0 select a register, so each register is aliased every 8 bytes.
- R2: A read at offset 1 returns {REMOTE_FLAG, SEC_ID[1:0], PRI_ID[4:0]}, with bit 7 the remote flag, bits 6:5 the secondary ID and bits 4:0 the primary ID.
- R3: A read at offset 5 returns EXT_ID when PRI_ID is 0, and 0x00 otherwise.
- R4: Any write at offset 1, whatever the data, clears the interrupt enable, the interrupt request, the DMA enables and the programmed level. It also drives cardReset high for exactly the one cycle after the write edge.
- R5: A write at offset 3 loads the interrupt enable from data bit 7 and the DMA enables from data bits 1:0. A read at offset 3 returns the enable in bit 7 and the DMA enables in bits 1:0, and bits 3:2 read as 0.
- R6: While rstN is low, every writable bit, the request, cardReset and all interrupt lines are 0.
- R7: The request (status bit 6) is set by a clock edge with reqPending high. It stays set across status reads and is cleared only by reqClear at an edge where reqPending is low.
- R8: Status bits 5:4 return the interrupt level. With LEVEL_PROG=0 the level comes from levelSw. With LEVEL_PROG=1 it comes from control data bits 5:4, which are written at offset 3.
- R9: One clock after request and enable are both set, irqLine holds exactly one bit, at index = level (index 0 = bus level 3, index 3 = level 6). irqLine is 0 one clock after either of them is clear.
- R10: Reads at offsets 0, 2, 4, 6 and 7 return 0x00, as does any cycle with rdEn low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rstN | input | 1 | Bus reset, active low, asynchronous |
| addr | input | 24 | Byte address |
| rdEn | input | 1 | Read cycle qualifier |
| wrEn | input | 1 | Write cycle qualifier |
| wrData | input | 8 | Write data |
| rdData | output | 8 | Read data, combinational during rdEn |
| reqPending | input | 1 | Raw request from the card core |
| reqClear | input | 1 | Request clear strobe from the card core |
| levelSw | input | 2 | Interrupt level switches |
| cardReset | output | 1 | One-cycle soft reset pulse to the core |
| irqLine | output | 4 | Bus interrupt lines for levels 3..6, active high |

## Verification
The bench builds two instances that share one bus.

The first uses PRI_ID=0, SEC_ID=2, EXT_ID=0xA7 and switch-sourced level. With these values the extension byte is readable, and switch changes can move the active interrupt line.

The second uses PRI_ID=5, SEC_ID=1, REMOTE_FLAG=1 and LEVEL_PROG=1. This shows the extension byte masked to zero, the remote flag in bit 7, and the level being taken from control writes rather than switches.

// File: rtl/cardRegsPkg.sv
package cardRegsPkg;
  localparam int OFS_ID   = 1;
  localparam int OFS_STAT = 3;
  localparam int OFS_EXT  = 5;

  typedef struct packed {
    logic cardRst;
    logic ctlWr;
    logic rdId;
    logic rdStat;
    logic rdExt;
  } regStrobe_t;
endpackage

// File: rtl/cardRegsCtrl.sv
module cardRegsCtrl
  import cardRegsPkg::*;
#(
  parameter int ADDR_W    = 24,
  parameter int WIN_W     = 16,
  parameter int OFS_W     = 3,
  parameter int CARD_SLOT = 8'h3C
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  output regStrobe_t        stb
);
  localparam int SLOT_W = ADDR_W - WIN_W;
  localparam logic [SLOT_W-1:0] SLOT_VAL = SLOT_W'(CARD_SLOT);

  logic             inWin;
  logic [OFS_W-1:0] ofs;
  logic             unusedAddrBits;

  assign inWin = (addr[ADDR_W-1:WIN_W] == SLOT_VAL);
  assign ofs   = addr[OFS_W-1:0];
  assign unusedAddrBits = ^addr[WIN_W-1:OFS_W];

  always_comb begin
    stb         = '0;
    stb.cardRst = inWin && wrEn && (ofs == OFS_W'(OFS_ID));
    stb.ctlWr   = inWin && wrEn && (ofs == OFS_W'(OFS_STAT));
    stb.rdId    = inWin && rdEn && (ofs == OFS_W'(OFS_ID));
    stb.rdStat  = inWin && rdEn && (ofs == OFS_W'(OFS_STAT));
    stb.rdExt   = inWin && rdEn && (ofs == OFS_W'(OFS_EXT));
  end

  // R1: nothing outside the card window may strobe a register
  assert_no_strobe_outside_R1: assert property (@(posedge clk) disable iff (!rstN)
    (addr[ADDR_W-1:WIN_W] != SLOT_VAL) |-> (stb == '0));

  // R10: at most one register is selected for a read
  assert_single_read_R10: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({stb.rdId, stb.rdStat, stb.rdExt}));
endmodule

// File: rtl/cardRegsDp.sv
module cardRegsDp
  import cardRegsPkg::*;
#(
  parameter int          DATA_W      = 8,
  parameter int          LVL_W       = 2,
  parameter logic [4:0]  PRI_ID      = 5'd0,
  parameter logic [1:0]  SEC_ID      = 2'd0,
  parameter logic [7:0]  EXT_ID      = 8'h00,
  parameter bit          REMOTE_FLAG = 1'b0,
  parameter bit          LEVEL_PROG  = 1'b0
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  regStrobe_t              stb,
  input  logic [DATA_W-1:0]       wrData,
  input  logic                    reqPending,
  input  logic                    reqClear,
  input  logic [LVL_W-1:0]        levelSw,
  output logic [DATA_W-1:0]       rdData,
  output logic                    cardReset,
  output logic [(1<<LVL_W)-1:0]   irqLine
);
  localparam int NUM_LINES = 1 << LVL_W;
  localparam int IE_BIT    = 7;
  localparam int IR_BIT    = 6;
  localparam int LVL_LO    = 4;

  logic             ie, ir;
  logic [1:0]       dmaEn;
  logic [LVL_W-1:0] progLvl, lvl;
  logic [DATA_W-1:0] idByte, statByte, extByte;
  logic             unusedIn;

  assign unusedIn = ^{wrData[6], wrData[3:2], levelSw, wrData[LVL_LO +: LVL_W]};

  generate
    if (LEVEL_PROG) begin : gLvlProg
      assign lvl = progLvl;
    end else begin : gLvlSw
      assign lvl = levelSw;
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ie        <= 1'b0;
      ir        <= 1'b0;
      dmaEn     <= '0;
      progLvl   <= '0;
      cardReset <= 1'b0;
    end else begin
      cardReset <= stb.cardRst;
      if (stb.cardRst) begin
        ie      <= 1'b0;
        ir      <= 1'b0;
        dmaEn   <= '0;
        progLvl <= '0;
      end else begin
        if (stb.ctlWr) begin
          ie      <= wrData[IE_BIT];
          dmaEn   <= wrData[1:0];
          progLvl <= wrData[LVL_LO +: LVL_W];
        end
        if (reqPending)    ir <= 1'b1;
        else if (reqClear) ir <= 1'b0;
      end
    end
  end

  generate
    for (genvar i = 0; i < NUM_LINES; i++) begin : gIrq
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) irqLine[i] <= 1'b0;
        else       irqLine[i] <= ie && ir && (lvl == LVL_W'(i));
      end
      // R9: a raised line matches the level of the previous cycle
      assert_irq_level_R9: assert property (@(posedge clk) disable iff (!rstN)
        irqLine[i] |-> ($past(lvl) == LVL_W'(i)));
    end
  endgenerate

  assign idByte   = {REMOTE_FLAG, SEC_ID, PRI_ID};
  assign extByte  = (PRI_ID == 5'd0) ? EXT_ID : 8'h00;
  assign statByte = {ie, ir, lvl, 2'b00, dmaEn};

  always_comb begin
    if (stb.rdId)        rdData = idByte;
    else if (stb.rdStat) rdData = statByte;
    else if (stb.rdExt)  rdData = extByte;
    else                 rdData = '0;
  end

  // R9: never more than one line
  assert_irq_onehot_R9: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(irqLine));
  // R9: a line needs request and enable one cycle earlier
  assert_irq_needs_cause_R9: assert property (@(posedge clk) disable iff (!rstN)
    (|irqLine) |-> $past(ie && ir));
  // R4: soft reset pulses and clears writable state
  assert_card_reset_R4: assert property (@(posedge clk) disable iff (!rstN)
    stb.cardRst |=> (cardReset && !ie && !ir && dmaEn == 2'b00));
  // R7: request stays set unless cleared without a pending input
  assert_ir_sticky_R7: assert property (@(posedge clk) disable iff (!rstN)
    (ir && !reqClear && !stb.cardRst) |=> ir);
endmodule

// File: rtl/cardRegs.sv
module cardRegs
  import cardRegsPkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int          CARD_SLOT   = 8'h3C,
  parameter logic [4:0]  PRI_ID      = 5'd0,
  parameter logic [1:0]  SEC_ID      = 2'd2,
  parameter logic [7:0]  EXT_ID      = 8'hA7,
  parameter bit          REMOTE_FLAG = 1'b0,
  parameter bit          LEVEL_PROG  = 1'b0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addr,
  input  logic              rdEn,
  input  logic              wrEn,
  input  logic [7:0]        wrData,
  output logic [7:0]        rdData,
  input  logic              reqPending,
  input  logic              reqClear,
  input  logic [1:0]        levelSw,
  output logic              cardReset,
  output logic [3:0]        irqLine
);
  regStrobe_t stb;

  cardRegsCtrl #(
    .ADDR_W(ADDR_W), .WIN_W(16), .OFS_W(3), .CARD_SLOT(CARD_SLOT)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .stb(stb)
  );

  cardRegsDp #(
    .DATA_W(8), .LVL_W(2), .PRI_ID(PRI_ID), .SEC_ID(SEC_ID), .EXT_ID(EXT_ID),
    .REMOTE_FLAG(REMOTE_FLAG), .LEVEL_PROG(LEVEL_PROG)
  ) dp_i (
    .clk(clk), .rstN(rstN), .stb(stb), .wrData(wrData),
    .reqPending(reqPending), .reqClear(reqClear), .levelSw(levelSw),
    .rdData(rdData), .cardReset(cardReset), .irqLine(irqLine)
  );
endmodule

// File: tb/cardRegs_tb_top.sv
module cardRegs_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [23:0] addr = '0;
  logic        rdEn = 1'b0, wrEn = 1'b0;
  logic [7:0]  wrData = '0;
  logic        reqPending = 1'b0, reqClear = 1'b0;
  logic [1:0]  levelSw = 2'b10;
  logic [7:0]  rdData, rdDataB;
  logic        cardReset, cardResetB;
  logic [3:0]  irqLine, irqLineB;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #5 clk = ~clk;

  cardRegs #(.CARD_SLOT(8'h3C), .PRI_ID(5'd0), .SEC_ID(2'd2), .EXT_ID(8'hA7),
             .REMOTE_FLAG(1'b0), .LEVEL_PROG(1'b0)) dut_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdData), .reqPending(reqPending), .reqClear(reqClear), .levelSw(levelSw),
    .cardReset(cardReset), .irqLine(irqLine));

  cardRegs #(.CARD_SLOT(8'h3C), .PRI_ID(5'd5), .SEC_ID(2'd1), .EXT_ID(8'h5A),
             .REMOTE_FLAG(1'b1), .LEVEL_PROG(1'b1)) dutB_i (
    .clk(clk), .rstN(rstN), .addr(addr), .rdEn(rdEn), .wrEn(wrEn), .wrData(wrData),
    .rdData(rdDataB), .reqPending(reqPending), .reqClear(reqClear), .levelSw(levelSw),
    .cardReset(cardResetB), .irqLine(irqLineB));

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual 0x%02h expected 0x%02h", req, act, exp);
    end
  endtask

  task automatic busWrite(input logic [23:0] a, input logic [7:0] d);
    @(negedge clk);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic busRead(input logic [23:0] a, output logic [7:0] dA, output logic [7:0] dB);
    @(negedge clk);
    addr = a; rdEn = 1'b1;
    #2;
    dA = rdData; dB = rdDataB;
    #1 rdEn = 1'b0;
  endtask

  // vector: {isWrite, addr, data, expected read of dut_i}
  typedef logic [40:0] vec_t;
  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    {1'b0, 24'h3C0001, 8'h00, 8'h40},  // R2 id byte
    {1'b0, 24'h3C0005, 8'h00, 8'hA7},  // R3 extension id
    {1'b0, 24'h3C0003, 8'h00, 8'h20},  // R8 switch level 10
    {1'b1, 24'h3C0003, 8'hFF, 8'h00},  // R5 write control
    {1'b0, 24'h3C0003, 8'h00, 8'hA3},  // R5 readback, bits 3:2 zero
    {1'b0, 24'h3CFFF3, 8'h00, 8'hA3},  // R1 alias in window
    {1'b0, 24'h3C0002, 8'h00, 8'h00},  // R10 empty offset
    {1'b0, 24'h3C0007, 8'h00, 8'h00},  // R10 empty offset
    {1'b0, 24'h3D0003, 8'h00, 8'h00},  // R1 outside reads zero
    {1'b1, 24'h3D0003, 8'h00, 8'h00},  // R1 outside write
    {1'b0, 24'h3C0003, 8'h00, 8'hA3},  // R1 state unchanged
    {1'b1, 24'h3C0009, 8'h12, 8'h00},  // R4 alias soft reset, odd data
    {1'b0, 24'h3C0003, 8'h00, 8'h20}   // R4 cleared
  };

  initial begin
    logic [7:0] a, b;
    #1;
    check("R6 cardReset in reset", {7'd0, cardReset}, 8'h00);
    check("R6 irqLine in reset", {4'd0, irqLine}, 8'h00);
    repeat (2) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      if (VECS[i][40]) busWrite(VECS[i][39:16], VECS[i][15:8]);
      else begin
        busRead(VECS[i][39:16], a, b);
        check($sformatf("vector %0d", i), a, VECS[i][7:0]);
      end
    end

    // R4: reset pulse of exactly one cycle
    busWrite(24'h3C0001, 8'h80);
    check("R4 pulse high", {7'd0, cardReset}, 8'h01);
    @(negedge clk);
    check("R4 pulse one cycle", {7'd0, cardReset}, 8'h00);

    // R7 and R9: request, routing, stickiness
    busWrite(24'h3C0003, 8'h80);
    @(negedge clk); reqPending = 1'b1;
    @(negedge clk); reqPending = 1'b0;
    check("R9 line not yet raised", {4'd0, irqLine}, 8'h00);
    @(negedge clk);
    check("R9 level 10 line", {4'd0, irqLine}, 8'h04);
    busRead(24'h3C0003, a, b);
    check("R7 request visible", a, 8'hE0);
    busRead(24'h3C0003, a, b);
    check("R7 read does not clear", a, 8'hE0);
    @(negedge clk); levelSw = 2'b11;
    @(negedge clk);
    check("R9 level 11 line", {4'd0, irqLine}, 8'h08);
    levelSw = 2'b00;
    @(negedge clk); @(negedge clk);
    check("R9 level 00 line", {4'd0, irqLine}, 8'h01);
    // R7: clear ignored while pending is high
    reqPending = 1'b1; reqClear = 1'b1;
    @(negedge clk); reqPending = 1'b0;
    @(negedge clk); reqClear = 1'b0;
    busRead(24'h3C0003, a, b);
    check("R7 cleared by strobe", a, 8'h80);
    @(negedge clk);
    check("R9 lines drop", {4'd0, irqLine}, 8'h00);

    // R8: programmable level instance
    busWrite(24'h3C0003, 8'h31);
    busRead(24'h3C0003, a, b);
    check("R8 prog level B", b, 8'h31);
    check("R8 switch level A", a, 8'h01);
    busRead(24'h3C0001, a, b);
    check("R2 id byte B", b, 8'hA5);
    busRead(24'h3C0005, a, b);
    check("R3 ext masked B", b, 8'h00);

    // R6: bus reset clears state
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    busRead(24'h3C0003, a, b);
    check("R6 status A after reset", a, 8'h00);
    check("R6 status B after reset", b, 8'h00);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    #1000000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule